// File: doc/BRIEF.md
# Serial EEPROM Doubleword Boot Loader

This block reads a range of 32-bit configuration words out of a two-wire serial EEPROM as soon as its reset is released. The words are then used as register defaults. It works on its own: no host access is needed. In the first cycle after reset it samples a presence input. If the EEPROM is reported present, the block runs one random-read transaction for each doubleword.

Each transaction has these steps:
- a start condition and the device address with the write direction;
- the 8-bit word address;
- a repeated start and the device address with the read direction;
- four data bytes, after which the bus is released with a stop condition.

The four bytes are packed into one word, with the first byte received in the top bits. The word is presented together with its word address for exactly one clock cycle. The word address starts at a configured first address and rises by four after every word. The run ends after the word at the configured last address, and the block then raises a completion flag. If the EEPROM fails to acknowledge any address byte, the block releases the bus with a stop and raises an error flag instead. The registers fed by the block then keep their own reset values.

Both bus lines are open drain. The block only ever pulls a line low, through an enable output, and reads the data line back through an input. The clock is a divider of the system clock: one bit slot lasts four quarter periods of `DIV` system cycles each.

Top module: `eeprom_dword_loader`

## Requirements
- R1: The load starts only if `present` is 1 in the first clock cycle after `rst_n` rises. Otherwise both line enables stay 0 and no start condition ever appears.
- R2: Every transaction is, in order: a start condition, byte `{DEV_ADDR,0}` (default 8'hA0), the word address, a repeated start, byte `{DEV_ADDR,1}` (default 8'hA1), four data bytes, and a stop condition. All bytes are sent MSB first, and each byte the block sends is followed by an acknowledge slot.
- R3: Word addresses go START_ADDR, START_ADDR+4, … up to END_ADDR. After the stop of the END_ADDR transaction, `done` goes to 1.
- R4: For each transaction, `word_valid` is 1 for exactly one cycle. At that cycle `word_addr` holds the word address and `word_data[31:24]` holds the first byte received, `[23:16]` the second, `[15:8]` the third and `[7:0]` the fourth.
- R5: In the slot after each of the first three data bytes the block pulls SDA low (acknowledge). After the fourth data byte it leaves SDA released (not acknowledge).
- R6: If SDA reads 1 in any acknowledge slot that follows a byte sent by the block, the block sends a stop, sets `err` to 1, produces no further words, and leaves `done` at 0.
- R7: SDA changes while SCL is high only as a start condition (falling) or a stop condition (rising), so each transaction shows exactly two starts and one stop.
- R8: While `rst_n` is 0, `scl_oe`, `sda_oe`, `word_valid`, `done` and `err` are all 0.
- R9: Once set, `done` and `err` hold until the next reset, and they are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release triggers the load |
| present | input | 1 | EEPROM detected; sampled in the first cycle after reset |
| sda_i | input | 1 | Level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| word_valid | output | 1 | One-cycle strobe: a word and its address are valid |
| word_addr | output | 8 | Word address of the loaded doubleword |
| word_data | output | 32 | Assembled doubleword, first byte in bits 31:24 |
| done | output | 1 | All words from START_ADDR to END_ADDR loaded |
| err | output | 1 | Load aborted on a missing acknowledge |

## Verification
The phase counter, bit counter and byte counter drive the line enables directly. A wrong value in any of them changes the bus within one quarter period: a misplaced SDA edge appears as an extra start or stop, and a shifted bit appears as a wrong device or address byte at the bus model. A fault in the assembly or address path shows up at the very next `word_valid` strobe as a wrong word or a wrong address. A fault in the end or abort decision shows up as a wrong count of words, or a missing or extra `done` or `err`, within one transaction. The runs cover the normal sequence and a missing acknowledge in each of the three address slots. They also cover an absent device, and the bench checks that the flags hold long after the load finishes.

// File: rtl/eeprom_dword_loader.sv
module eeprom_dword_loader #(
  parameter int         DIV        = 4,
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter logic [7:0] START_ADDR = 8'h00,
  parameter logic [7:0] END_ADDR   = 8'h3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        present,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        word_valid,
  output logic [7:0]  word_addr,
  output logic [31:0] word_data,
  output logic        done,
  output logic        err
);
  localparam int CW = $clog2(DIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RX, S_STOP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  q;
  logic [3:0]  bitn;
  logic [1:0]  bytec;
  logic [1:0]  txsel;
  logic        rep, abort, first;
  logic [7:0]  addr;
  logic [31:0] sh;
  logic [7:0]  txbyte;

  wire tick = (cnt == CW'(DIV - 1));
  assign txbyte = (txsel == 2'd1) ? addr : {DEV_ADDR, txsel == 2'd2};

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (q == 2'd0) ? rep : (q == 2'd3);
        sda_oe = q[1];
      end
      S_TX: begin
        scl_oe = (q[1] == q[0]);
        sda_oe = (bitn != 4'd8) && !txbyte[~bitn[2:0]];
      end
      S_RX: begin
        scl_oe = (q[1] == q[0]);
        sda_oe = (bitn == 4'd8) && (bytec != 2'd3);
      end
      S_STOP: begin
        scl_oe = (q == 2'd0);
        sda_oe = !q[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; q <= '0; bitn <= '0; bytec <= '0;
      txsel <= '0; rep <= 1'b0; abort <= 1'b0; first <= 1'b1;
      addr <= START_ADDR; sh <= '0;
      word_valid <= 1'b0; word_addr <= '0; word_data <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      first <= 1'b0;
      word_valid <= 1'b0;
      if (first && present) begin
        st <= S_START; cnt <= '0; q <= '0; rep <= 1'b0; txsel <= 2'd0;
        addr <= START_ADDR;
      end else if (st != S_IDLE) begin
        if (!tick) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          q   <= q + 1'b1;
          if (q == 2'd2) begin
            if (st == S_TX && bitn == 4'd8 && sda_i) abort <= 1'b1;
            if (st == S_RX && bitn != 4'd8) sh <= {sh[30:0], sda_i};
          end
          if (q == 2'd3) begin
            case (st)
              S_START: begin st <= S_TX; bitn <= '0; end
              S_TX: begin
                bitn <= '0;
                if (bitn != 4'd8) bitn <= bitn + 1'b1;
                else if (abort) st <= S_STOP;
                else if (txsel == 2'd0) txsel <= 2'd1;
                else if (txsel == 2'd1) begin
                  st <= S_START; rep <= 1'b1; txsel <= 2'd2;
                end else begin
                  st <= S_RX; bytec <= '0;
                end
              end
              S_RX: begin
                bitn <= '0;
                if (bitn != 4'd8) bitn <= bitn + 1'b1;
                else if (bytec == 2'd3) begin
                  st <= S_STOP;
                  word_valid <= 1'b1; word_data <= sh; word_addr <= addr;
                end else bytec <= bytec + 1'b1;
              end
              S_STOP: begin
                if (abort) begin
                  st <= S_IDLE; err <= 1'b1;
                end else if (addr == END_ADDR) begin
                  st <= S_IDLE; done <= 1'b1;
                end else begin
                  addr <= addr + 8'd4; st <= S_START; rep <= 1'b0; txsel <= 2'd0;
                end
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

  // R4
  wv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R3
  wv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_addr >= START_ADDR && word_addr <= END_ADDR));
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R7
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe))
      |-> (st == S_START || st == S_STOP));
  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/sim_eeprom_dword_loader.sv
module sim_eeprom_dword_loader;
  localparam int         DIV = 2;
  localparam logic [7:0] SA  = 8'h10;
  localparam logic [7:0] EA  = 8'h1C;
  localparam int         NW  = 4;

  logic clk = 1'b0, rst_n = 1'b0, present = 1'b0;
  logic scl_oe, sda_oe, word_valid, done, err;
  logic [7:0] word_addr;
  logic [31:0] word_data;
  logic drv;
  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | drv);

  always #5 clk = ~clk;

  eeprom_dword_loader #(.DIV(DIV), .DEV_ADDR(7'h50), .START_ADDR(SA), .END_ADDR(EA)) u0 (
    .clk(clk), .rst_n(rst_n), .present(present), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .word_valid(word_valid),
    .word_addr(word_addr), .word_data(word_data), .done(done), .err(err));

  function automatic logic [7:0] eb(input logic [7:0] x);
    return 8'(x * 8'd29 + 8'd7);
  endfunction

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // word capture
  int nwd;
  logic [7:0]  wa [0:15];
  logic [31:0] wd [0:15];
  always @(negedge clk) begin
    if (!rst_n) nwd = 0;
    else if (word_valid && nwd < 16) begin
      wa[nwd] = word_addr; wd[nwd] = word_data; nwd++;
    end
  end

  // EEPROM model and bus monitor
  int nack_t = -1, nack_k = 0;
  int starts, stops, nd, nwa, nk, txn, cnt, mode, nxt;
  bit psc, psd, skip, endrd;
  logic [7:0] sh, ptr, rb;
  logic [7:0] dlog [0:31];
  logic [7:0] wlog [0:31];
  bit         klog [0:63];

  always @(scl_w or sda_w or rst_n) begin
    if (!rst_n) begin
      starts = 0; stops = 0; nd = 0; nwa = 0; nk = 0; txn = -1;
      cnt = 0; mode = 3; nxt = 3; skip = 0; endrd = 0; drv = 1'b0;
      sh = 0; ptr = 0; rb = 0;
    end else if (scl_w && psc && psd && !sda_w) begin
      starts++; mode = 0; cnt = 0; skip = 1; endrd = 0; drv = 1'b0;
    end else if (scl_w && psc && !psd && sda_w) begin
      stops++; mode = 3; drv = 1'b0;
    end else if (scl_w && !psc) begin
      if (cnt < 8 && (mode == 0 || mode == 1)) sh = {sh[6:0], sda_w};
      if (cnt == 8 && mode == 2) begin
        if (nk < 64) klog[nk] = sda_w;
        nk++;
        if (sda_w) endrd = 1;
      end
    end else if (!scl_w && psc) begin
      if (skip) begin
        skip = 0; drv = 1'b0;
      end else if (mode == 3) begin
        drv = 1'b0;
      end else if (cnt < 8) begin
        cnt++;
        if (cnt == 8) begin
          if (mode == 2) drv = 1'b0;
          else begin
            bit nack;
            nack = 0;
            if (mode == 0) begin
              if (sh == 8'hA0) txn++;
              if (nd < 32) dlog[nd] = sh;
              nd++;
              if (sh[7:1] != 7'h50) nack = 1;
              if (txn == nack_t && nack_k == (sh[0] ? 2 : 0)) nack = 1;
              nxt = sh[0] ? 2 : 1;
            end else begin
              ptr = sh;
              if (nwa < 32) wlog[nwa] = sh;
              nwa++;
              if (txn == nack_t && nack_k == 1) nack = 1;
              nxt = 0;
            end
            if (nack) nxt = 3;
            drv = !nack;
          end
        end else if (mode == 2) drv = ~rb[7 - cnt];
      end else begin
        cnt = 0; drv = 1'b0;
        if (mode == 2) begin
          if (endrd) mode = 3;
          else begin ptr = ptr + 8'd1; rb = eb(ptr); drv = ~rb[7]; end
        end else begin
          mode = nxt;
          if (mode == 2) begin rb = eb(ptr); drv = ~rb[7]; end
        end
      end
    end
    psc = scl_w; psd = sda_w;
  end

  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 200000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic run(input bit pres, input int nt, input int nkind, input int limit);
    rst_n = 1'b0; present = pres; nack_t = nt; nack_k = nkind;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8
    chk(!scl_oe && !sda_oe && !word_valid && !done && !err, "R8 reset state",
        {scl_oe, sda_oe, word_valid, done, err}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < limit && !done && !err; i++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    // normal load
    run(1'b1, -1, 0, 20000);
    chk(done && !err, "R3 done after last word", {done, err}, 2'b10);
    chk(nwd == NW, "R3 word count", nwd, NW);
    for (int i = 0; i < NW; i++) begin
      logic [7:0] a;
      a = SA + 8'(4 * i);
      chk(wa[i] == a, "R3 word address", wa[i], a);
      chk(wd[i] == {eb(a), eb(a + 8'd1), eb(a + 8'd2), eb(a + 8'd3)}, "R4 word data",
          wd[i], {eb(a), eb(a + 8'd1), eb(a + 8'd2), eb(a + 8'd3)});
      chk(wlog[i] == a, "R2 word address on bus", wlog[i], a);
      chk(dlog[2*i] == 8'hA0 && dlog[2*i+1] == 8'hA1, "R2 device bytes",
          {dlog[2*i], dlog[2*i+1]}, 16'hA0A1);
      for (int b = 0; b < 4; b++)
        chk(klog[4*i+b] == (b == 3), "R5 master acknowledge", klog[4*i+b], (b == 3));
    end
    chk(starts == 2 * NW && stops == NW, "R7 start and stop count",
        {starts[15:0], stops[15:0]}, {16'(2 * NW), 16'(NW)});
    chk(!scl_oe && !sda_oe, "R2 bus released after load", {scl_oe, sda_oe}, 0);
    repeat (300) @(negedge clk);
    chk(done && !err && nwd == NW, "R9 done holds", {done, err}, 2'b10);

    // missing ack on word address of second transaction
    run(1'b1, 1, 1, 20000);
    chk(err && !done, "R6 err on address nack", {done, err}, 2'b01);
    chk(nwd == 1 && wa[0] == SA, "R6 words before abort", nwd, 1);
    chk(stops == 2 && starts == 3, "R6 stop after nack", {starts[15:0], stops[15:0]}, {16'd3, 16'd2});
    repeat (300) @(negedge clk);
    chk(err && !done && nwd == 1 && starts == 3, "R9 err holds, R6 no more traffic",
        {done, err, 8'(nwd)}, {1'b0, 1'b1, 8'd1});

    // missing ack on read-direction device byte, first transaction
    run(1'b1, 0, 2, 20000);
    chk(err && !done && nwd == 0, "R6 nack on read address", {done, err, 8'(nwd)}, 10'h100);
    chk(stops == 1 && nk == 0, "R6 no data bytes read", {stops[7:0], nk[7:0]}, 16'h0100);

    // missing ack on write-direction device byte, third transaction
    run(1'b1, 2, 0, 20000);
    chk(err && !done && nwd == 2, "R6 nack on write address", {done, err, 8'(nwd)}, 10'h102);
    chk(nwa == 2, "R6 no address after nack", nwa, 2);

    // absent device
    run(1'b0, -1, 0, 600);
    chk(starts == 0 && stops == 0, "R1 no bus traffic when absent",
        {starts[15:0], stops[15:0]}, 0);
    chk(!done && !err && nwd == 0 && !scl_oe && !sda_oe, "R1 idle when absent",
        {done, err, scl_oe, sda_oe}, 0);

    // device appears after the sampling cycle
    present = 1'b1;
    repeat (200) @(negedge clk);
    chk(starts == 0 && nwd == 0, "R1 late present ignored", starts, 0);

    // full load again after the aborted runs
    run(1'b1, -1, 0, 20000);
    chk(done && nwd == NW && wa[NW-1] == EA, "R3 reload after reset", wa[NW-1], EA);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule